// File: doc/BRIEF.md
# Erasure-Seeded Locator and Evaluator Solver

This block sits between the syndrome stage and the root search of a byte-wide Reed-Solomon decoder for a code with sixteen check symbols. It takes the sixteen syndromes of one received word and a rate selector that names the shortening and puncturing profile. It returns the error/erasure locator polynomial and the error evaluator polynomial, then pulses `done` for one cycle.

Puncturing removes the trailing check symbols, and the profile gives how many were removed. Those symbols are known erasures. The locator register is first built as the product of one linear factor per erased position. A sequential Berlekamp iteration then runs over the remaining syndrome steps. The iteration never inverts a field element. It scales the running locator by the last nonzero discrepancy, so the result is a nonzero multiple of the monic locator. The roots are unchanged. The last cycle multiplies the syndrome polynomial by the locator and keeps the terms below x^16. When every syndrome is zero, the iteration is skipped and the erasure product is returned at once.

Top module: `rsbm_locator_solver`

## Requirements
- R1: The rate selector chooses the erasure count B: selector 0→8, 1→12, 2→0, 3→8, 4→4, 5→4. Selectors 6 and 7 give 0.
- R2: Arithmetic is in GF(256) with field polynomial x^8+x^4+x^3+x^2+1 and primitive element alpha = 0x02. The erased positions are degrees 0..B-1 of the received polynomial, with locators alpha^0..alpha^(B-1). When all syndromes are zero, `lam_out` equals the product of (1 + alpha^i x) over i < B exactly, with constant term 1.
- R3: Syndrome j (j = 0..15) is the received polynomial evaluated at alpha^j and arrives on `syn_in[8j+7:8j]`. Suppose e errors at degrees p (0..254, not erased) plus the B erasures satisfy 2e+B ≤ 16. Then the locator is zero at alpha^(-p) for every error and erased degree, and at no other nonzero field element.
- R4: `lam_out[8k+7:8k]` is the coefficient of x^k, for k = 0..16. The constant coefficient is nonzero whenever `done` is high.
- R5: `omega_out[8k+7:8k]` (k = 0..15) equals the coefficient of x^k in the syndrome polynomial times `lam_out`, reduced mod x^16.
- R6: When any syndrome is nonzero, `done` rises 18 clock edges after the edge that accepts `start`, whatever the profile.
- R7: When all syndromes are zero, `done` rises B+2 edges after the accepting edge, and `omega_out` is zero.
- R8: `done` is high for exactly one cycle. `lam_out` and `omega_out` keep their values until the next `done`.
- R9: A `start` that arrives while a word is being solved is ignored. The result and timing of the word in progress are unchanged.
- R10: Synchronous reset clears `done`, `lam_out` and `omega_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept syndromes and selector when idle |
| rate_id | input | 3 | Puncturing profile selector |
| syn_in | input | 128 | Sixteen syndromes, syndrome j in byte j |
| done | output | 1 | One-cycle result strobe |
| lam_out | output | 136 | Locator coefficients, x^k in byte k |
| omega_out | output | 128 | Evaluator coefficients, x^k in byte k |

## Verification
Assertions check on every cycle that `done` is a single-cycle pulse and that the outputs are stable outside the evaluation cycle. They also check that the scaling factor and the constant locator term stay nonzero during the iteration, and that the length register stays within range. Whether the locator has the correct roots can only be shown by the bench scenarios. The bench places errors and erasures in every profile, forms the syndromes arithmetically, and sweeps all 255 nonzero field elements for roots. The same scenarios cover the evaluator product, the latency for each profile, and the handling of a second start mid-solve.

// File: rtl/rsbm_pkg.sv
package rsbm_pkg;
    parameter int SW   = 8;
    parameter int NSYN = 16;
    localparam int NLAM = NSYN + 1;
    localparam int RW   = 3;
    localparam int CW   = $clog2(NSYN + 1);
    localparam int SIW  = $clog2(NSYN);
    localparam logic [SW-1:0] FIELD_LOW = SW'(8'h1D);

    typedef logic [SW-1:0] sym_t;
    typedef logic [CW-1:0] cnt_t;
    typedef enum logic [1:0] {ST_IDLE, ST_SEED, ST_ITER, ST_EVAL} phase_e;

    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SW; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[SW-1] ? ((sh << 1) ^ FIELD_LOW) : (sh << 1);
        end
        return acc;
    endfunction

    function automatic cnt_t erase_count(input logic [RW-1:0] rid);
        case (rid)
            3'd0:    return cnt_t'(8);
            3'd1:    return cnt_t'(12);
            3'd3:    return cnt_t'(8);
            3'd4:    return cnt_t'(4);
            3'd5:    return cnt_t'(4);
            default: return cnt_t'(0);
        endcase
    endfunction
endpackage

// File: rtl/rsbm_ctrl.sv
module rsbm_ctrl
    import rsbm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [RW-1:0] rate_id,
    input  logic          syn_zero,
    output phase_e        phase,
    output cnt_t          step,
    output cnt_t          n_era
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= ST_IDLE;
            step  <= '0;
            n_era <= '0;
        end else begin
            case (phase)
                ST_IDLE: if (start) begin
                    n_era <= erase_count(rate_id);
                    step  <= '0;
                    phase <= ST_SEED;
                end
                ST_SEED: begin
                    if (step == n_era) phase <= syn_zero ? ST_EVAL : ST_ITER;
                    else               step  <= step + 1'b1;
                end
                ST_ITER: begin
                    step <= step + 1'b1;
                    if (step == cnt_t'(NSYN - 1)) phase <= ST_EVAL;
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end

    // R9: a start during seeding cannot pull the sequencer back to idle
    a_r9_busy_start: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_SEED && start) |=> (phase != ST_IDLE));
    // R6: iteration never runs past the last syndrome step
    a_r6_step_bound: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_ITER) |-> (step < cnt_t'(NSYN)));
    // R1: seeding never counts past the selected erasure count
    a_r1_seed_bound: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_SEED) |-> (step <= n_era));
endmodule

// File: rtl/rsbm_core.sv
module rsbm_core
    import rsbm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  phase_e              phase,
    input  cnt_t                step,
    input  cnt_t                n_era,
    input  logic [NSYN*SW-1:0]  syn_in,
    output logic                syn_zero,
    output sym_t [NSYN-1:0]     syn_q,
    output sym_t [NLAM-1:0]     lam
);
    sym_t [NLAM-1:0] aux;
    sym_t            gam;
    sym_t            mu;
    cnt_t            len;

    sym_t            delta;
    sym_t [NLAM-1:0] seed_next;
    sym_t [NLAM-1:0] upd_next;
    logic [CW:0]     twice_len;
    logic [CW:0]     lim;
    logic [CW:0]     new_len;
    int              idx;

    assign syn_zero = (syn_q == '0);

    always_comb begin
        delta = '0;
        idx   = 0;
        for (int j = 0; j < NSYN; j++) begin
            idx = int'(step) - j;
            if (idx >= 0 && idx < NSYN)
                delta = delta ^ gf_mul(lam[j], syn_q[idx[SIW-1:0]]);
        end
        seed_next[0] = lam[0];
        upd_next[0]  = gf_mul(gam, lam[0]);
        for (int k = 1; k < NLAM; k++) begin
            seed_next[k] = lam[k] ^ gf_mul(mu, lam[k-1]);
            upd_next[k]  = gf_mul(gam, lam[k]) ^ gf_mul(delta, aux[k-1]);
        end
        twice_len = {len, 1'b0};
        lim       = {1'b0, step} + {1'b0, n_era};
        new_len   = lim + 1'b1 - {1'b0, len};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            syn_q <= '0;
            lam   <= '0;
            aux   <= '0;
            gam   <= '0;
            mu    <= '0;
            len   <= '0;
        end else begin
            case (phase)
                ST_IDLE: if (start) begin
                    syn_q  <= syn_in;
                    lam    <= '0;
                    lam[0] <= sym_t'(1);
                    mu     <= sym_t'(1);
                end
                ST_SEED: begin
                    if (step != n_era) begin
                        lam <= seed_next;
                        mu  <= gf_mul(mu, sym_t'(2));
                    end else begin
                        aux <= lam;
                        gam <= sym_t'(1);
                        len <= n_era;
                    end
                end
                ST_ITER: begin
                    lam <= upd_next;
                    if (delta != '0 && twice_len <= lim) begin
                        aux <= lam;
                        gam <= delta;
                        len <= new_len[CW-1:0];
                    end else begin
                        aux <= {aux[NLAM-2:0], sym_t'(0)};
                    end
                end
                default: ;
            endcase
        end
    end

    // R4: register length stays within the syndrome count
    a_r4_len_bound: assert property (@(posedge clk) disable iff (rst)
        len <= cnt_t'(NSYN));
    // R4: the scaling factor is never zero while iterating
    a_r4_gamma_nz: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_ITER) |-> (gam != '0));
    // R4: the running locator keeps a nonzero constant term
    a_r4_lead_nz: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_ITER) |-> (lam[0] != '0));
endmodule

// File: rtl/rsbm_eval.sv
module rsbm_eval
    import rsbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase,
    input  sym_t [NSYN-1:0]  syn_q,
    input  sym_t [NLAM-1:0]  lam,
    output sym_t [NLAM-1:0]  lam_q,
    output sym_t [NSYN-1:0]  omega_q,
    output logic             done
);
    sym_t [NSYN-1:0] om;

    always_comb begin
        for (int k = 0; k < NSYN; k++) begin
            om[k] = '0;
            for (int j = 0; j <= k; j++)
                om[k] = om[k] ^ gf_mul(syn_q[j], lam[k-j]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lam_q   <= '0;
            omega_q <= '0;
            done    <= 1'b0;
        end else begin
            done <= (phase == ST_EVAL);
            if (phase == ST_EVAL) begin
                lam_q   <= lam;
                omega_q <= om;
            end
        end
    end

    // R8: the strobe lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8: results only move on the evaluation edge
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (phase != ST_EVAL) |=> ($stable(lam_q) && $stable(omega_q)));
    // R4: a published locator has a nonzero constant term
    a_r4_out_lead: assert property (@(posedge clk) disable iff (rst)
        done |-> (lam_q[0] != '0));
endmodule

// File: rtl/rsbm_locator_solver.sv
module rsbm_locator_solver
    import rsbm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [RW-1:0]       rate_id,
    input  logic [NSYN*SW-1:0]  syn_in,
    output logic                done,
    output logic [NLAM*SW-1:0]  lam_out,
    output logic [NSYN*SW-1:0]  omega_out
);
    phase_e          phase;
    cnt_t            step;
    cnt_t            n_era;
    logic            syn_zero;
    sym_t [NSYN-1:0] syn_q;
    sym_t [NLAM-1:0] lam;
    sym_t [NLAM-1:0] lam_q;
    sym_t [NSYN-1:0] omega_q;

    rsbm_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .rate_id(rate_id),
        .syn_zero(syn_zero), .phase(phase), .step(step), .n_era(n_era)
    );

    rsbm_core u_core (
        .clk(clk), .rst(rst), .start(start), .phase(phase), .step(step),
        .n_era(n_era), .syn_in(syn_in), .syn_zero(syn_zero),
        .syn_q(syn_q), .lam(lam)
    );

    rsbm_eval u_eval (
        .clk(clk), .rst(rst), .phase(phase), .syn_q(syn_q), .lam(lam),
        .lam_q(lam_q), .omega_q(omega_q), .done(done)
    );

    assign lam_out   = lam_q;
    assign omega_out = omega_q;
endmodule

// File: tb/sim_rsbm_locator_solver.sv
module sim_rsbm_locator_solver;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [2:0]   rate_id = 3'd0;
    logic [127:0] syn_in = '0;
    logic         done;
    logic [135:0] lam_out;
    logic [127:0] omega_out;

    int n_err = 0;
    int n_chk = 0;
    bit finished = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #10 clk = ~clk;

    rsbm_locator_solver u0 (
        .clk(clk), .rst(rst), .start(start), .rate_id(rate_id),
        .syn_in(syn_in), .done(done), .lam_out(lam_out), .omega_out(omega_out)
    );

    function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11D << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] apw(input int e);
        logic [7:0] r;
        r = 8'd1;
        for (int i = 0; i < (e % 255); i++) r = gm(r, 8'd2);
        return r;
    endfunction

    function automatic logic [7:0] peval(input logic [135:0] p, input logic [7:0] x);
        logic [7:0] r;
        r = '0;
        for (int k = 16; k >= 0; k--) r = gm(r, x) ^ p[8*k +: 8];
        return r;
    endfunction

    function automatic int bprof(input int rid);
        case (rid)
            0: return 8;
            1: return 12;
            3: return 8;
            4: return 4;
            5: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int rnd();
        rng = rng * 32'd1664525 + 32'd1013904223;
        return int'(rng[30:8]);
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [135:0] act, input logic [135:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic run_case(input int rid, input int bcnt, input int nerr,
                            input bit zero_era, input bit mid_start, output int lat);
        int pos[32];
        logic [7:0] val[32];
        logic [7:0] s[16];
        logic [127:0] syn;
        logic [127:0] om_exp;
        logic [135:0] lam_keep;
        logic [127:0] om_keep;
        int np, mism, p, exp_lat;
        bit dup, allzero, got, expz, held;
        np = 0;
        for (int i = 0; i < bcnt; i++) begin
            pos[np] = i;
            val[np] = zero_era ? 8'd0 : 8'(rnd() % 256);
            np++;
        end
        for (int e = 0; e < nerr; e++) begin
            do begin
                p = bcnt + rnd() % (255 - bcnt);
                dup = 0;
                for (int i = 0; i < np; i++) if (pos[i] == p) dup = 1;
            end while (dup);
            pos[np] = p;
            val[np] = 8'(1 + rnd() % 255);
            np++;
        end
        for (int j = 0; j < 16; j++) begin
            s[j] = '0;
            for (int i = 0; i < np; i++) s[j] = s[j] ^ gm(val[i], apw(j * pos[i]));
            syn[8*j +: 8] = s[j];
        end
        allzero = (syn == '0);

        @(negedge clk);
        rate_id = 3'(rid);
        syn_in  = syn;
        start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        got = 0;
        while (!got && lat < 60) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (done) got = 1;
            else if (mid_start && lat == 4) begin
                start   = 1'b1;
                syn_in  = ~syn;
                rate_id = 3'(7 - rid);
            end else start = 1'b0;
        end
        start = 1'b0;

        exp_lat = allzero ? bcnt + 2 : 18;
        if (allzero) chk(lat == exp_lat, "R7 latency", 136'(lat), 136'(exp_lat));
        else         chk(lat == exp_lat, "R6 latency", 136'(lat), 136'(exp_lat));

        mism = 0;
        for (int q = 0; q < 255; q++) begin
            expz = 0;
            for (int i = 0; i < np; i++) if (pos[i] == q) expz = 1;
            if ((peval(lam_out, apw(255 - q)) == 8'd0) != expz) mism++;
        end
        if (allzero) chk(mism == 0, "R2 erasure roots", 136'(mism), 136'(0));
        else         chk(mism == 0, "R3 locator roots", 136'(mism), 136'(0));
        if (mid_start) chk(mism == 0 && lat == exp_lat, "R9 start ignored while busy",
                           136'(lat), 136'(exp_lat));
        chk(lam_out[7:0] != 8'd0, "R4 constant term", 136'(lam_out[7:0]), 136'(1));

        for (int k = 0; k < 16; k++) begin
            om_exp[8*k +: 8] = '0;
            for (int j = 0; j <= k; j++)
                om_exp[8*k +: 8] = om_exp[8*k +: 8] ^ gm(s[j], lam_out[8*(k-j) +: 8]);
        end
        chk(omega_out == om_exp, "R5 evaluator", 136'(omega_out), 136'(om_exp));
        if (allzero) begin
            chk(lam_out[7:0] == 8'd1, "R2 seed constant", 136'(lam_out[7:0]), 136'(1));
            chk(omega_out == '0, "R7 evaluator zero", 136'(omega_out), 136'(0));
        end

        lam_keep = lam_out;
        om_keep  = omega_out;
        held = 1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            if (done || lam_out != lam_keep || omega_out != om_keep) held = 0;
        end
        chk(held, "R8 pulse and hold", 136'(lam_out), 136'(lam_keep));
    endtask

    initial begin
        int lat, b;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R10 reset done", 136'(done), 136'(0));
        chk(lam_out == '0, "R10 reset locator", lam_out, 136'(0));
        chk(omega_out == '0, "R10 reset evaluator", 136'(omega_out), 136'(0));
        rst = 1'b0;

        for (int rid = 0; rid < 8; rid++) begin
            run_case(rid, bprof(rid), 0, 1, 0, lat);
            chk(lat == bprof(rid) + 2, "R1 profile erasure count", 136'(lat), 136'(bprof(rid) + 2));
        end

        for (int rid = 0; rid < 8; rid++) begin
            b = bprof(rid);
            for (int e = 0; e <= (16 - b) / 2; e++)
                for (int t = 0; t < 3; t++)
                    run_case(rid, b, e, 0, (t == 2), lat);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule